// File: doc/BRIEF.md
# Write-Once Supply Configuration Register

This block holds the supply configuration of a chip in a 32-bit register that sits on a simple word-addressed write/read port with byte enables. The lowest byte selects the supply arrangement: bit 0 is bypass, bit 1 is regulator enable and bit 2 is configuration-update enable. After a power-on reset this byte takes exactly one write. The bytes above it can be rewritten at any time.

Every write to the low byte is checked. Bypass and regulator enable set together is the one invalid value. An invalid write is dropped and the default value stays, but the write still uses up the single allowed write. From then on the levels-valid status stays low until the next power-on reset.

A second register holds backup-domain control. It is write-protected and only accepts writes while an unlock bit in a control register is set. There are two resets. `por_ni` clears everything. `rst_ni` clears only the unlock bit, so the supply register, its lock, the invalid flag and the backup register all survive it.

Top module: `supply_cfg_regs`

## Requirements
- R1: After power-on reset the supply register reads 0x0000_0006 (regulator enabled, bypass off, update enabled), the control and backup registers read 0, the lock is open and `levels_ok_o` is 1.
- R2: The first write with byte enable 0 set stores the low byte of a valid value and closes the lock. Any later write to the low byte is ignored.
- R3: Bytes 1 to 3 of the supply register take every write whose byte enable is set, whether the lock is open or closed.
- R4: A low-byte write with bit 0 and bit 1 both 1 is not stored and the previous low byte is kept, yet it closes the lock.
- R5: After an invalid low-byte write, `levels_ok_o` and status bit 0 stay 0 until the next power-on reset, whatever is written later.
- R6: When no invalid write has occurred, `levels_ok_o` is 1 exactly when one of bypass (bit 0) and regulator enable (bit 1) is set.
- R7: `rst_ni` clears the unlock bit and leaves the supply register, the lock, the invalid flag and the backup register unchanged.
- R8: A write to the backup register changes it only while unlock bit 8 of the control register is 1.
- R9: A write updates only the byte lanes whose byte enable is set. A write to the supply register with byte enable 0 clear does not close the lock.
- R10: The byte offsets are: control 0x00, backup 0x04, supply 0x08 and status 0x0C. Status is read-only, with bit 0 the levels-valid flag and bit 1 the lock. Writes to status are ignored, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Active-low asynchronous power-on reset, clears all state |
| rst_ni | input | 1 | Active-low asynchronous system reset, clears only the unlock bit |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| addr_i | input | 5 | Byte address, word aligned |
| be_i | input | 4 | Byte enables for the write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| levels_ok_o | output | 1 | Supply levels valid |

## Verification
The assertions assume that `wr_en_i`, `addr_i`, `be_i` and `wdata_i` are stable at each rising edge. They also assume that every write completes in the single cycle in which it is strobed. The bench meets this by changing inputs only on falling edges and holding each strobe for exactly one cycle. The assertions also assume that `por_ni` stays low long enough to cover at least one edge. The bench meets this by holding each reset pulse over a rising edge before releasing it on a falling edge.

// File: rtl/supply_cfg_pkg.sv
package supply_cfg_pkg;
  localparam int unsigned BYP_BIT    = 0;
  localparam int unsigned LDO_BIT    = 1;
  localparam int unsigned UPD_BIT    = 2;
  localparam int unsigned UNLOCK_BIT = 8;

  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_BKP    = 3'd1,
    SEL_SUPPLY = 3'd2,
    SEL_STAT   = 3'd3
  } reg_sel_e;

  function automatic logic cfg_valid(input logic [7:0] v);
    return !(v[BYP_BIT] && v[LDO_BIT]);
  endfunction
endpackage

// File: rtl/supply_cfg_wo.sv
module supply_cfg_wo
  import supply_cfg_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter logic [7:0]  LOW_RST = 8'h06
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              wr_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] value_o,
  output logic              locked_o,
  output logic              levels_ok_o
);
  localparam int unsigned NB = DATA_W / 8;

  logic [7:0] low_q;
  logic       lock_q;
  logic       bad_q;
  logic       low_wr;

  assign low_wr = wr_i && be_i[0] && !lock_q;

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      low_q  <= LOW_RST;
      lock_q <= 1'b0;
      bad_q  <= 1'b0;
    end else if (low_wr) begin
      lock_q <= 1'b1;
      if (cfg_valid(wdata_i[7:0])) low_q <= wdata_i[7:0];
      else                         bad_q <= 1'b1;
    end
  end

  assign value_o[7:0] = low_q;

  for (genvar b = 1; b < NB; b++) begin : g_lane
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni)               q <= '0;
      else if (wr_i && be_i[b])  q <= wdata_i[b*8 +: 8];
    end
    assign value_o[b*8 +: 8] = q;
  end

  assign locked_o    = lock_q;
  assign levels_ok_o = !bad_q && (low_q[BYP_BIT] ^ low_q[LDO_BIT]);

  assert_lock_sticky_R2: assert property (@(posedge clk_i) disable iff (!por_ni)
    lock_q |=> lock_q);
  assert_low_frozen_R2: assert property (@(posedge clk_i) disable iff (!por_ni)
    lock_q |=> $stable(low_q));
  assert_invalid_dropped_R4: assert property (@(posedge clk_i) disable iff (!por_ni)
    (wr_i && be_i[0] && !lock_q && !cfg_valid(wdata_i[7:0]))
      |=> ($stable(low_q) && lock_q && !levels_ok_o));
  assert_bad_holds_R5: assert property (@(posedge clk_i) disable iff (!por_ni)
    !levels_ok_o && lock_q && !(low_q[BYP_BIT] ^ low_q[LDO_BIT]) |=> !levels_ok_o);
endmodule

// File: rtl/bkp_guard.sv
module bkp_guard #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                por_ni,
  input  logic                unlock_i,
  input  logic                wr_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   q_o
);
  localparam int unsigned NB = DATA_W / 8;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni)                          q <= '0;
      else if (wr_i && unlock_i && be_i[b]) q <= wdata_i[b*8 +: 8];
    end
    assign q_o[b*8 +: 8] = q;
  end

  assert_locked_stable_R8: assert property (@(posedge clk_i) disable iff (!por_ni)
    !unlock_i |=> $stable(q_o));
endmodule

// File: rtl/supply_cfg_regs.sv
module supply_cfg_regs
  import supply_cfg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              levels_ok_o
);
  localparam int unsigned NB = DATA_W / 8;
  localparam int unsigned WA = ADDR_W - 2;

  logic [WA-1:0]     word;
  logic              sys_rst_n;
  logic              unlock_q;
  logic              wr_ctrl, wr_bkp, wr_sup;
  logic [DATA_W-1:0] bkp_val, sup_val;
  logic              locked;

  assign word      = addr_i[ADDR_W-1:2];
  assign sys_rst_n = por_ni && rst_ni;
  assign wr_ctrl   = wr_en_i && (word == WA'(SEL_CTRL));
  assign wr_bkp    = wr_en_i && (word == WA'(SEL_BKP));
  assign wr_sup    = wr_en_i && (word == WA'(SEL_SUPPLY));

  always_ff @(posedge clk_i or negedge sys_rst_n) begin
    if (!sys_rst_n)                         unlock_q <= 1'b0;
    else if (wr_ctrl && be_i[UNLOCK_BIT/8]) unlock_q <= wdata_i[UNLOCK_BIT];
  end

  supply_cfg_wo #(.DATA_W(DATA_W)) u_supply (
    .clk_i       (clk_i),
    .por_ni      (por_ni),
    .wr_i        (wr_sup),
    .be_i        (be_i[NB-1:0]),
    .wdata_i     (wdata_i[DATA_W-1:0]),
    .value_o     (sup_val),
    .locked_o    (locked),
    .levels_ok_o (levels_ok_o)
  );

  bkp_guard #(.DATA_W(DATA_W)) u_bkp (
    .clk_i    (clk_i),
    .por_ni   (por_ni),
    .unlock_i (unlock_q),
    .wr_i     (wr_bkp),
    .be_i     (be_i[NB-1:0]),
    .wdata_i  (wdata_i[DATA_W-1:0]),
    .q_o      (bkp_val)
  );

  always_comb begin
    rdata_o = '0;
    case (word)
      WA'(SEL_CTRL):   rdata_o[UNLOCK_BIT] = unlock_q;
      WA'(SEL_BKP):    rdata_o = 32'(bkp_val);
      WA'(SEL_SUPPLY): rdata_o = 32'(sup_val);
      WA'(SEL_STAT):   rdata_o[1:0] = {locked, levels_ok_o};
      default:         rdata_o = '0;
    endcase
  end

  assert_sysrst_keeps_lock_R7: assert property (@(posedge clk_i) disable iff (!por_ni)
    (locked && !rst_ni) |=> locked);
  assert_unlock_cleared_R7: assert property (@(posedge clk_i) disable iff (!por_ni)
    !rst_ni |-> !unlock_q);
endmodule

// File: tb/supply_cfg_regs_tb_top.sv
`timescale 1ns/1ps
module supply_cfg_regs_tb_top;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        lvl_ok;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  supply_cfg_regs dut_i (
    .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n), .wr_en_i(wr_en),
    .addr_i(addr), .be_i(be), .wdata_i(wdata), .rdata_o(rdata),
    .levels_ok_o(lvl_ok)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    addr = a; wdata = d; be = b; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; be = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic do_por();
    @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
    @(negedge clk); @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
  endtask

  task automatic do_sysrst();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(5'h08, d); chk(d, 32'h0000_0006, "R1 supply reset");
    rd(5'h00, d); chk(d, 32'h0, "R1 ctrl reset");
    rd(5'h04, d); chk(d, 32'h0, "R1 bkp reset");
    rd(5'h0C, d); chk(d, 32'h1, "R1 status reset");
    chk(32'(lvl_ok), 32'h1, "R1 levels_ok reset");
  endtask

  task automatic t_upper_no_lock();
    logic [31:0] d;
    wr(5'h08, 32'hAABB_CC03, 4'b1110);
    rd(5'h08, d); chk(d, 32'hAABB_CC06, "R9 lane mask");
    rd(5'h0C, d); chk(d, 32'h1, "R9 lock still open");
  endtask

  task automatic t_first_and_second();
    logic [31:0] d;
    wr(5'h08, 32'h1122_3301, 4'b1111);
    rd(5'h08, d); chk(d, 32'h1122_3301, "R2 first write");
    rd(5'h0C, d); chk(d, 32'h3, "R2 R6 status locked bypass");
    wr(5'h08, 32'h0000_0002, 4'b0001);
    rd(5'h08, d); chk(d, 32'h1122_3301, "R2 second write ignored");
  endtask

  task automatic t_upper_rewrite();
    logic [31:0] d;
    wr(5'h08, 32'h5566_7702, 4'b1110);
    rd(5'h08, d); chk(d, 32'h5566_7701, "R3 upper rewrite");
    wr(5'h08, 32'h0000_9900, 4'b0010);
    rd(5'h08, d); chk(d, 32'h5566_9901, "R3 single lane rewrite");
  endtask

  task automatic t_backup();
    logic [31:0] d;
    wr(5'h04, 32'h0000_DEAD, 4'b1111);
    rd(5'h04, d); chk(d, 32'h0, "R8 protected write dropped");
    wr(5'h00, 32'h0000_0100, 4'b0010);
    rd(5'h00, d); chk(d, 32'h0000_0100, "R8 unlock set");
    wr(5'h04, 32'h0000_DEAD, 4'b1111);
    rd(5'h04, d); chk(d, 32'h0000_DEAD, "R8 unlocked write");
  endtask

  task automatic t_status_ro();
    logic [31:0] d;
    wr(5'h0C, 32'h0, 4'b1111);
    rd(5'h0C, d); chk(d, 32'h3, "R10 status read-only");
    rd(5'h10, d); chk(d, 32'h0, "R10 unmapped reads zero");
  endtask

  task automatic t_sysrst();
    logic [31:0] d;
    do_sysrst();
    rd(5'h00, d); chk(d, 32'h0, "R7 unlock cleared");
    rd(5'h04, d); chk(d, 32'h0000_DEAD, "R7 backup kept");
    rd(5'h08, d); chk(d, 32'h5566_9901, "R7 supply kept");
    rd(5'h0C, d); chk(d, 32'h3, "R7 lock kept");
    wr(5'h04, 32'h0000_BEEF, 4'b1111);
    rd(5'h04, d); chk(d, 32'h0000_DEAD, "R8 relocked after sys reset");
  endtask

  task automatic t_invalid();
    logic [31:0] d;
    do_por();
    t_reset();
    wr(5'h08, 32'h0000_0003, 4'b0001);
    rd(5'h08, d); chk(d, 32'h0000_0006, "R4 invalid not stored");
    rd(5'h0C, d); chk(d, 32'h2, "R4 R5 locked and not ok");
    chk(32'(lvl_ok), 32'h0, "R5 levels_ok low");
    wr(5'h08, 32'h0000_0001, 4'b0001);
    rd(5'h08, d); chk(d, 32'h0000_0006, "R4 later write ignored");
    chk(32'(lvl_ok), 32'h0, "R5 still low");
    do_sysrst();
    chk(32'(lvl_ok), 32'h0, "R5 R7 survives sys reset");
    do_por();
    chk(32'(lvl_ok), 32'h1, "R5 cleared by POR");
  endtask

  task automatic t_no_source();
    logic [31:0] d;
    wr(5'h08, 32'h0000_0004, 4'b0001);
    rd(5'h08, d); chk(d, 32'h0000_0004, "R6 stored no source");
    chk(32'(lvl_ok), 32'h0, "R6 neither bypass nor regulator");
  endtask

  initial begin
    do_por();
    t_reset();
    t_upper_no_lock();
    t_first_and_second();
    t_upper_rewrite();
    t_backup();
    t_status_ro();
    t_sysrst();
    t_invalid();
    t_no_source();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule